// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an asynchronous serial line into parallel characters. It shares an oversampling clock enable (eight enables per bit) with the transmitter, so the receive side runs at the same baud rate. The word length, stop-bit count and parity mode are set on static configuration inputs. A frame begins with a falling edge on an idle line. The start bit is checked again at its midpoint, and every later bit is sampled once, at the middle of its slot. Data arrives least significant bit first.

Each finished frame produces one character with three flags. The break flag means the whole frame, stop slot included, was received as zero. The framing flag means a stop slot was sampled low. The parity flag reports a parity mismatch, or, in user parity mode, the level of the received parity bit. The character and its flags stay on the output until the consumer takes them through a valid/ready handshake. A resynchronised copy of the line level is also available, so the line can be watched directly.

Top module: `uart_rx_classify`

## Requirements
- R1: A frame starts when an idle line falls between two successive enable samples. The start bit is sampled again on the fourth enable after that edge. If the line is high there, the frame is dropped and no character is produced.
- R2: `cfg_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits are received LSB first into `out_data[0]` upward, and unused upper bits read 0.
- R3: `cfg_par` selects the parity mode: 00 none (no parity slot), 01 even, 10 user, 11 odd. With even or odd parity, `out_par_flag` is 1 exactly when the received parity bit does not match the data. With no parity it is 0.
- R4: In user parity mode, `out_par_flag` equals the received parity bit, whatever the data is.
- R5: `cfg_two_stop` = 0 gives one stop slot and 1 gives two. `out_frm_err` is 1 when any stop slot is sampled low.
- R6: When the data, parity and all stop slots are all received as 0, the character has `out_brk` = 1 and `out_frm_err` = 1. Its parity flag follows R3 for the received zeros.
- R7: After a break, no new frame starts until the line has been sampled high.
- R8: While `out_valid` is high and `out_ready` is low, the data and flags hold steady. A frame that completes during that time is discarded.
- R9: One clock after a handshake (`out_valid` and `out_ready` both high), `out_valid`, `out_data` and all flags read 0, unless a new character loads in that same cycle.
- R10: `line_level` follows `rxd` with a delay of two clocks.
- R11: The configuration is captured at the start edge. Changing it during a frame does not affect that frame.
- R12: After reset, `out_valid`, `out_data` and all flags are 0 and `line_level` is 1.
- R13: `out_valid` rises one clock after the enable that samples the middle of the last stop slot, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, eight per bit period |
| rxd | input | 1 | Serial line input |
| cfg_len | input | 2 | Data length select |
| cfg_two_stop | input | 1 | Two stop slots when 1 |
| cfg_par | input | 2 | Parity mode select |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Consumer accepts the character |
| out_data | output | 8 | Received character |
| out_par_flag | output | 1 | Parity mismatch, or the received parity bit in user mode |
| out_frm_err | output | 1 | Stop slot sampled low |
| out_brk | output | 1 | Whole frame received as zero |
| line_level | output | 1 | Synchronised line level |

## Verification
The bench issues one enable every four clocks, so each bit lasts 32 clocks. Because of the two-flop synchronizer and the phase of the enable, the midpoint sample of a slot falls 18 to 21 clocks into that slot. A character is therefore due by clock 22 of the last stop slot. The bench checks `out_valid` is still low 12 clocks into that slot and high when the slot ends. `line_level` is checked at both one and two clocks after a change of `rxd`. The clearing after a handshake is checked on the falling edge after the accepting clock.

// File: rtl/uart_rx_classify.sv
module uart_rx_classify #(
  parameter int OVERSAMPLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  input  logic [1:0] cfg_par,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_par_flag,
  output logic       out_frm_err,
  output logic       out_brk,
  output logic       line_level
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF = CW'(OVERSAMPLE / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BRK} st_t;

  st_t        st;
  logic [1:0] sync;
  logic       rx_s, prev;
  logic [CW-1:0] cnt;
  logic [2:0] idx;
  logic [7:0] shreg;
  logic [1:0] l_len, l_par;
  logic       l_two, ones, pbit, zero, ferr;
  logic       mid_hit, last_stop, frame_done, fe_final, brk_final, pf_final, in_slot;

  assign rx_s       = sync[1];
  assign line_level = rx_s;
  assign in_slot    = (st == S_DATA) || (st == S_PAR) || (st == S_STOP1) || (st == S_STOP2);
  assign mid_hit    = tick && in_slot && (cnt == LAST);
  assign last_stop  = (st == S_STOP2) || (st == S_STOP1 && !l_two);
  assign frame_done = mid_hit && last_stop;
  assign fe_final   = ferr | ~rx_s;
  assign brk_final  = zero & ~rx_s;

  always_comb begin
    case (l_par)
      2'b01:   pf_final = ones ^ pbit;
      2'b10:   pf_final = pbit;
      2'b11:   pf_final = ~(ones ^ pbit);
      default: pf_final = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; prev <= 1'b0; cnt <= '0; idx <= '0; shreg <= '0;
      l_len <= 2'b11; l_par <= 2'b00; l_two <= 1'b0;
      ones <= 1'b0; pbit <= 1'b0; zero <= 1'b1; ferr <= 1'b0;
    end else begin
      if (tick && in_slot) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (tick) begin
          prev <= rx_s;
          if (prev && !rx_s) begin
            st <= S_START; cnt <= '0; idx <= '0; shreg <= '0;
            l_len <= cfg_len; l_par <= cfg_par; l_two <= cfg_two_stop;
            ones <= 1'b0; pbit <= 1'b0; zero <= 1'b1; ferr <= 1'b0;
          end
        end
        S_START: if (tick) begin
          if (cnt == HALF) begin
            cnt <= '0;
            if (rx_s) begin st <= S_IDLE; prev <= 1'b1; end
            else st <= S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (mid_hit) begin
          shreg[idx] <= rx_s;
          ones <= ones ^ rx_s;
          zero <= zero & ~rx_s;
          idx  <= idx + 1'b1;
          if (idx == 3'd4 + {1'b0, l_len}) st <= (l_par == 2'b00) ? S_STOP1 : S_PAR;
        end
        S_PAR: if (mid_hit) begin
          pbit <= rx_s;
          zero <= zero & ~rx_s;
          st   <= S_STOP1;
        end
        S_STOP1, S_STOP2: if (mid_hit) begin
          ferr <= fe_final;
          zero <= brk_final;
          if (!last_stop) st <= S_STOP2;
          else begin
            st   <= brk_final ? S_BRK : S_IDLE;
            prev <= rx_s;
          end
        end
        S_BRK: if (tick && rx_s) begin st <= S_IDLE; prev <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
      out_par_flag <= 1'b0; out_frm_err <= 1'b0; out_brk <= 1'b0;
    end else if (frame_done && (!out_valid || out_ready)) begin
      out_valid <= 1'b1; out_data <= shreg;
      out_par_flag <= pf_final; out_frm_err <= fe_final; out_brk <= brk_final;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0; out_data <= '0;
      out_par_flag <= 1'b0; out_frm_err <= 1'b0; out_brk <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_classify_chk.sv
module uart_rx_classify_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxd,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_par_flag,
  input logic       out_frm_err,
  input logic       out_brk,
  input logic       line_level,
  input logic       frame_done
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_par_flag)
      && $stable(out_frm_err) && $stable(out_brk)); // R8
  AST_BREAK_HAS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_brk |-> out_frm_err); // R6
  AST_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_done |=> !out_valid && out_data == 8'h00
      && !out_brk && !out_frm_err && !out_par_flag); // R9
  AST_NO_FLAGS_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_brk && !out_frm_err && !out_par_flag); // R9
  AST_LOAD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_done)); // R13
  AST_LINE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd3 |-> line_level == $past(rxd, 2)); // R10
endmodule

bind uart_rx_classify uart_rx_classify_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_par_flag(out_par_flag), .out_frm_err(out_frm_err),
  .out_brk(out_brk), .line_level(line_level), .frame_done(frame_done)
);

// File: tb/sim_uart_rx_classify.sv
module sim_uart_rx_classify;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'b11, cfg_par = 2'b00;
  logic cfg_two_stop = 1'b0, out_ready = 1'b0;
  logic out_valid, out_par_flag, out_frm_err, out_brk, line_level;
  logic [7:0] out_data;
  logic [1:0] tc = '0;
  int checks = 0, errors = 0;

  uart_rx_classify u0 (.*);

  always #10 clk = ~clk;
  always @(negedge clk) begin tc <= tc + 1'b1; tick <= (tc == 2'd3); end

  // {data, len, two, par, flip, badstop, exp_data, exp_par, exp_frm, exp_brk}
  localparam logic [25:0] VEC [11] = '{
    {8'hA5, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b0},
    {8'h07, 2'd3, 1'b0, 2'd3, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b0},
    {8'hFF, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 1'b0},
    {8'h2A, 2'd1, 1'b1, 2'd3, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 1'b0},
    {8'h55, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0},
    {8'h80, 2'd3, 1'b0, 2'd2, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0},
    {8'h12, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1, 1'b0},
    {8'hC3, 2'd3, 1'b1, 2'd1, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0},
    {8'hE7, 2'd2, 1'b1, 2'd3, 1'b1, 1'b0, 8'h67, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk) rxd = b;
    repeat (31) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    @(negedge clk) rxd = 1'b1;
    repeat (n * 32 - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two,
                      input logic [1:0] par, input logic flip, input logic bad,
                      input logic pre, input logic swap_cfg);
    int n = 5 + int'(len);
    logic [7:0] dm = d & ((8'h01 << n) - 8'h01);
    logic pb;
    cfg_len = len; cfg_two_stop = two; cfg_par = par;
    pb = (par == 2'd2) ? flip : (((par == 2'd3) ? ~^dm : ^dm) ^ flip);
    slot(1'b0);
    if (swap_cfg) begin cfg_len = ~len; cfg_par = ~par; cfg_two_stop = ~two; end
    for (int i = 0; i < n; i++) slot(dm[i]);
    if (par != 2'd0) slot(pb);
    if (two) slot(1'b1);
    @(negedge clk) rxd = ~bad;
    repeat (12) @(negedge clk);
    if (pre) check("R13 early", out_valid, 1'b0);
    repeat (19) @(negedge clk);
    @(negedge clk) rxd = 1'b1;
    cfg_len = len; cfg_two_stop = two; cfg_par = par;
  endtask

  task automatic take();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    check("R9 valid", out_valid, 1'b0);
    check("R9 flags", {out_data, out_par_flag, out_frm_err, out_brk}, 11'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    check("R12 valid", out_valid, 1'b0);
    check("R12 data", {out_data, out_par_flag, out_frm_err, out_brk}, 11'd0);
    check("R12 line", line_level, 1'b1);
    rst_n = 1'b1;
    idle_bits(2);

    // R10 line level delay
    @(negedge clk) rxd = 1'b0;
    @(negedge clk) check("R10 one clock", line_level, 1'b1);
    @(negedge clk) check("R10 two clocks", line_level, 1'b0);
    rxd = 1'b1;
    idle_bits(3);

    // R1 short glitch abandoned
    @(negedge clk) rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    idle_bits(16);
    check("R1 glitch", out_valid, 1'b0);

    // table walk: R2 R3 R4 R5 R13
    for (int k = 0; k < 11; k++) begin
      logic [25:0] v = VEC[k];
      send(v[25:18], v[17:16], v[15], v[14:13], v[12], v[11], 1'b1, 1'b0);
      check("R13 due", out_valid, 1'b1);
      check("R2 data", out_data, v[10:3]);
      check(v[14:13] == 2'd2 ? "R4 user bit" : "R3 parity", out_par_flag, v[2]);
      check("R5 framing", out_frm_err, v[1]);
      check("R6 no break", out_brk, v[0]);
      take();
      idle_bits(1);
    end

    // R8 stall holds, second frame discarded
    send(8'h11, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle_bits(1);
    send(8'h22, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 held", {out_valid, out_data}, {1'b1, 8'h11});
    take();
    idle_bits(2);
    check("R8 discarded", out_valid, 1'b0);

    // R11 configuration captured at start
    send(8'hB6, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 data", {out_valid, out_data}, {1'b1, 8'hB6});
    check("R11 flags", {out_par_flag, out_frm_err, out_brk}, 3'b000);
    take();
    idle_bits(1);

    // R6 break, even parity, 8 bits
    cfg_len = 2'd3; cfg_par = 2'd1; cfg_two_stop = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (12 * 32) @(negedge clk);
    check("R6 break", {out_valid, out_brk, out_frm_err, out_par_flag, out_data}, {4'b1110, 8'h00});
    take();
    // R7 no new frame while line stays low
    repeat (20 * 32) @(negedge clk);
    check("R7 still low", out_valid, 1'b0);
    idle_bits(1);
    send(8'h5A, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 resumes", {out_valid, out_brk, out_data}, {2'b10, 8'h5A});
    take();
    idle_bits(1);

    // R6 break with odd parity sets parity flag
    cfg_len = 2'd0; cfg_par = 2'd3; cfg_two_stop = 1'b1;
    @(negedge clk) rxd = 1'b0;
    repeat (12 * 32) @(negedge clk);
    check("R6 odd break", {out_valid, out_brk, out_frm_err, out_par_flag}, 4'b1111);
    take();
    idle_bits(2);
    summary();
  end
endmodule